// File: doc/BRIEF.md
# Programmable Memory Wait/Acknowledge Generator

This block drives the single handshake line that a memory controller presents to a CPU. A configuration write picks one of two styles. In wait style the line is raised as soon as a chip-selected access begins and is dropped once the access can finish. In acknowledge style the line rests low and is raised once the data can be taken. A two-bit delay field sets how many extra clock periods the block waits before it signals ready. The count starts when the access starts (wait style) or when the row strobe starts (acknowledge style).

The countdown is held back while any blocking condition is present: precharge still pending, refresh running, the external wait-in input, or an arbitration grant that is not valid. An optional half-cycle stage delays the move to ready by half a clock period. With burst toggling enabled, the handshake follows the column strobes during page bursts. The line returns to not-ready when the strobes release, and each new strobe beat runs the programmed delay again. Dropping the access request ends the access and returns the line to low.

Top module: `mem_hshake_gen`

## Requirements
- R1: A synchronous reset makes `hs_o` low and clears every configuration field to zero (wait style, delay 0, half-cycle off, burst off).
- R2: In wait style (`cfg_ack_mode`=0), `hs_o` goes high at the edge that samples `cs` and `areq` both high while idle. With delay D and nothing blocking, it goes low D+1 edges later.
- R3: In acknowledge style (`cfg_ack_mode`=1), `hs_o` stays low during the access until `row_start` is sampled high. It goes high D+1 edges after that edge when nothing is blocking.
- R4: On any edge that samples `pchg_pend`, `rfsh_busy`, `wait_in` or `grant_bad` high during the countdown, the count reloads to D. Ready then comes D+1 unblocked edges after the last blocked edge.
- R5: With `cfg_burst`=1 and the line in its ready state, sampling all `cas_n` bits high after any was low puts the line in its not-ready state. Wait style shows high and acknowledge style shows low. The next sampled strobe assertion (any `cas_n` bit low) starts a new D+1 count.
- R6: With `cfg_burst`=0, column-strobe activity after ready has no effect on `hs_o` while `areq` stays high.
- R7: An edge that samples `areq` low during an access ends it. `hs_o` is low from then on, whatever `cas_n` and `row_start` do, until a new chip-selected access begins.
- R8: `areq` sampled high with `cs` low starts no access, and `hs_o` stays low.
- R9: With `cfg_half`=1, the move to the ready state shows on `hs_o` only after the following falling clock edge. The move away from ready is not delayed.
- R10: A high `cfg_we` loads `cfg_ack_mode`, `cfg_delay`, `cfg_half` and `cfg_burst` at the rising edge. The loaded values govern the accesses that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_ack_mode | input | 1 | 0 = wait style, 1 = acknowledge style |
| cfg_delay | input | DLY_W | Extra clock periods before ready |
| cfg_half | input | 1 | Enable half-cycle stage on the move to ready |
| cfg_burst | input | 1 | Enable column-strobe burst toggling |
| cs | input | 1 | Chip select |
| areq | input | 1 | Access request, high for the access duration |
| row_start | input | 1 | Row strobe start event |
| cas_n | input | NCAS | Column strobes, active low |
| wait_in | input | 1 | External wait request |
| pchg_pend | input | 1 | Precharge time not yet satisfied |
| rfsh_busy | input | 1 | Refresh in progress |
| grant_bad | input | 1 | Arbitration grant not valid |
| hs_o | output | 1 | CPU handshake line, active high |

## Verification
The bench goes after blocking flags that arrive in the middle of a countdown. A design that only paused the count, instead of reloading it, would signal ready too early. It drops `areq` during a burst gap and pulses `row_start` after the access has ended, which catches a design that lets the line rise again outside an access. It samples both clock phases in half-cycle mode. A design that delayed the fall as well as the rise would show a stale ready for half a cycle at the start of the next beat or access. It also drives strobe release with burst disabled, where a wrong design would drop the acknowledge line in the middle of an access.

// File: rtl/mem_hshake_gen.sv
module mem_hshake_gen #(
  parameter int NCAS  = 4,
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_ack_mode,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             cfg_half,
  input  logic             cfg_burst,
  input  logic             cs,
  input  logic             areq,
  input  logic             row_start,
  input  logic [NCAS-1:0]  cas_n,
  input  logic             wait_in,
  input  logic             pchg_pend,
  input  logic             rfsh_busy,
  input  logic             grant_bad,
  output logic             hs_o
);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COUNT, S_READY, S_GAP} st_t;

  st_t              st;
  logic [DLY_W-1:0] cnt;
  logic             mode_ack, half_en, burst_en;
  logic [DLY_W-1:0] dly;
  logic             cas_prev, rdy_n;

  wire cas_any = ~&cas_n;
  wire blocked = wait_in | pchg_pend | rfsh_busy | grant_bad;
  wire cas_rel = cas_prev & ~cas_any;
  wire cas_beg = cas_any & ~cas_prev;
  wire rdy     = (st == S_READY);
  wire rdy_eff = half_en ? (rdy & rdy_n) : rdy;
  wire act     = (st != S_IDLE);

  assign hs_o = act & (mode_ack ? rdy_eff : ~rdy_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_ack <= 1'b0;
      dly      <= '0;
      half_en  <= 1'b0;
      burst_en <= 1'b0;
    end else if (cfg_we) begin
      mode_ack <= cfg_ack_mode;
      dly      <= cfg_delay;
      half_en  <= cfg_half;
      burst_en <= cfg_burst;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      cas_prev <= 1'b0;
    end else begin
      cas_prev <= cas_any;
      if (act && !areq) begin
        st <= S_IDLE;
      end else begin
        unique case (st)
          S_IDLE:
            if (cs && areq) begin
              st  <= mode_ack ? S_ROW : S_COUNT;
              cnt <= dly;
            end
          S_ROW:
            if (row_start) begin
              st  <= S_COUNT;
              cnt <= dly;
            end
          S_COUNT:
            if (blocked)       cnt <= dly;
            else if (cnt == 0) st  <= S_READY;
            else               cnt <= cnt - 1'b1;
          S_READY:
            if (burst_en && cas_rel) st <= S_GAP;
          S_GAP:
            if (cas_beg) begin
              st  <= S_COUNT;
              cnt <= dly;
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(negedge clk) begin
    if (rst) rdy_n <= 1'b0;
    else     rdy_n <= rdy;
  end

  assert_areq_end_R7: assert property (@(posedge clk) disable iff (rst)
    (!areq) |=> (st == S_IDLE));

  assert_no_cs_no_start_R8: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !cs) |=> (st == S_IDLE));

  assert_blocked_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (st == S_COUNT && blocked && areq) |=> (st == S_COUNT && cnt == $past(dly)));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_COUNT && !blocked && areq && cnt != 0) |=> (cnt == $past(cnt) - 1'b1));

  assert_row_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_ROW && !row_start && areq) |=> (st == S_ROW));

  assert_no_burst_R6: assert property (@(posedge clk) disable iff (rst)
    (st == S_READY && !burst_en && areq) |=> (st == S_READY));

endmodule

// File: tb/mem_hshake_gen_tb.sv
module mem_hshake_gen_tb_top;
  localparam int CLK_P = 10;
  localparam int NCAS  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0, cfg_ack_mode = 0, cfg_half = 0, cfg_burst = 0;
  logic [1:0] cfg_delay = 0;
  logic cs = 0, areq = 0, row_start = 0;
  logic [NCAS-1:0] cas_n = '1;
  logic wait_in = 0, pchg_pend = 0, rfsh_busy = 0, grant_bad = 0;
  logic hs_o;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  mem_hshake_gen #(.NCAS(NCAS), .DLY_W(2)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ack_mode(cfg_ack_mode),
    .cfg_delay(cfg_delay), .cfg_half(cfg_half), .cfg_burst(cfg_burst),
    .cs(cs), .areq(areq), .row_start(row_start), .cas_n(cas_n),
    .wait_in(wait_in), .pchg_pend(pchg_pend), .rfsh_busy(rfsh_busy),
    .grant_bad(grant_bad), .hs_o(hs_o));

  int m_st = 0, m_cnt = 0;
  bit m_casp = 0, m_ack = 0, m_half = 0, m_burst = 0, m_prev_rdy = 0;
  int m_dly = 0;

  function automatic bit exp_hs(bit phase_b);
    bit r, eff;
    r   = (m_st == 3);
    eff = (m_half && !phase_b) ? (r && m_prev_rdy) : r;
    if (m_st == 0) return 1'b0;
    return m_ack ? eff : !eff;
  endfunction

  task automatic model_edge();
    bit blk, ca;
    blk = wait_in | pchg_pend | rfsh_busy | grant_bad;
    ca  = ~&cas_n;
    m_prev_rdy = (m_st == 3);
    if (m_st != 0 && !areq) m_st = 0;
    else case (m_st)
      0: if (cs && areq) begin m_st = m_ack ? 1 : 2; m_cnt = m_dly; end
      1: if (row_start) begin m_st = 2; m_cnt = m_dly; end
      2: if (blk) m_cnt = m_dly; else if (m_cnt == 0) m_st = 3; else m_cnt--;
      3: if (m_burst && m_casp && !ca) m_st = 4;
      4: if (ca && !m_casp) begin m_st = 2; m_cnt = m_dly; end
      default: m_st = 0;
    endcase
    m_casp = ca;
    if (cfg_we) begin
      m_ack = cfg_ack_mode; m_dly = cfg_delay; m_half = cfg_half; m_burst = cfg_burst;
    end
  endtask

  task automatic check(string tag, bit act, bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s t=%0t hs_o=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk); #1;
    model_edge();
    check(tag, hs_o, exp_hs(1'b0));
    @(negedge clk); #1;
    check(tag, hs_o, exp_hs(1'b1));
  endtask

  task automatic idle_in();
    cfg_we = 0; cs = 0; areq = 0; row_start = 0; cas_n = '1;
    wait_in = 0; pchg_pend = 0; rfsh_busy = 0; grant_bad = 0;
  endtask

  task automatic load_cfg(bit a, int d, bit h, bit b, string tag);
    idle_in();
    cfg_we = 1; cfg_ack_mode = a; cfg_delay = d[1:0]; cfg_half = h; cfg_burst = b;
    step(tag);
    cfg_we = 0;
    step(tag);
  endtask

  task automatic steps(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    idle_in();
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R1 reset", hs_o, 1'b0);
    rst = 0;
    steps(2, "R1");

    // R1: configuration cleared -> wait style, delay 0
    cs = 1; areq = 1; steps(3, "R1 cfg zero");
    idle_in(); steps(2, "R7");

    // R2 + R10: wait style delay 2
    load_cfg(0, 2, 0, 0, "R10");
    cs = 1; areq = 1; steps(5, "R2");
    idle_in(); steps(2, "R7");

    // R3 + R10: acknowledge style delay 3
    load_cfg(1, 3, 0, 0, "R10");
    cs = 1; areq = 1; steps(3, "R3 before row");
    row_start = 1; step("R3"); row_start = 0; steps(5, "R3");
    idle_in(); steps(2, "R7");

    // R4: each blocking flag mid-count
    load_cfg(0, 2, 0, 0, "R10");
    cs = 1; areq = 1; step("R4");
    pchg_pend = 1; steps(2, "R4 pchg"); pchg_pend = 0; step("R4");
    rfsh_busy = 1; step("R4 rfsh"); rfsh_busy = 0; step("R4");
    wait_in = 1; steps(2, "R4 wait_in"); wait_in = 0; step("R4");
    grant_bad = 1; step("R4 grant"); grant_bad = 0; steps(4, "R4");
    idle_in(); steps(2, "R7");

    // R5: burst toggling, both styles
    for (int a = 0; a < 2; a++) begin
      load_cfg(a[0], 1, 0, 1, "R10");
      cs = 1; areq = 1; cas_n = '0; row_start = 1; step("R5"); row_start = 0;
      steps(3, "R5");
      for (int b = 0; b < 3; b++) begin
        cas_n = '1; steps(2, "R5 release");
        cas_n = 4'b1101; steps(3, "R5 beat");
      end
      idle_in(); steps(2, "R7");
    end

    // R6: burst off, strobe release has no effect
    load_cfg(1, 0, 0, 0, "R10");
    cs = 1; areq = 1; cas_n = '0; row_start = 1; step("R6"); row_start = 0;
    steps(2, "R6");
    cas_n = '1; steps(3, "R6 release"); cas_n = '0; steps(2, "R6");
    idle_in(); steps(2, "R7");

    // R7: drop areq in a burst gap, then strobe/row activity
    load_cfg(0, 0, 0, 1, "R10");
    cs = 1; areq = 1; cas_n = '0; steps(3, "R7");
    cas_n = '1; steps(2, "R7 gap");
    areq = 0; cs = 0; step("R7 end");
    cas_n = '0; row_start = 1; steps(3, "R7 after end");
    idle_in(); step("R7");

    // R8: areq without cs
    areq = 1; steps(4, "R8"); idle_in(); step("R8");

    // R9: half-cycle stage, both styles with burst
    for (int a = 0; a < 2; a++) begin
      load_cfg(a[0], 1, 1, 1, "R10");
      cs = 1; areq = 1; cas_n = '0; row_start = 1; step("R9"); row_start = 0;
      steps(3, "R9");
      cas_n = '1; steps(2, "R9 release"); cas_n = '0; steps(3, "R9 beat");
      idle_in(); steps(2, "R9");
    end

    // Random accesses
    for (int n = 0; n < 60; n++) begin
      load_cfg($urandom_range(0, 1), $urandom_range(0, 3),
               $urandom_range(0, 1), $urandom_range(0, 1), "R10 rnd");
      cs = 1; areq = 1;
      for (int c = 0, len = $urandom_range(4, 20); c < len; c++) begin
        row_start = ($urandom_range(0, 3) == 0);
        cas_n     = ($urandom_range(0, 2) == 0) ? '1 : NCAS'($urandom_range(0, 14));
        wait_in   = ($urandom_range(0, 7) == 0);
        pchg_pend = ($urandom_range(0, 9) == 0);
        rfsh_busy = ($urandom_range(0, 11) == 0);
        grant_bad = ($urandom_range(0, 11) == 0);
        cs        = ($urandom_range(0, 3) != 0);
        step(m_ack ? "R3 rnd" : "R2 rnd");
      end
      idle_in(); steps($urandom_range(1, 3), "R7 rnd");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule